// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block controls the reset release and the low-power state of a small processor subsystem. After a reset request it holds the CPU in reset for a number of cycles chosen by the kind of reset. For a power-on reset driven by an external clock, it also waits for the clock to be reported stable before letting the CPU run.

While the CPU is running, a write of the power-down bit stops the clock tree by dropping both the oscillator enable and the PLL enable. Three wake sources can end power-down: USB bus activity, a primary wake pin with selectable polarity, and a second wake pin that can be given over to general-purpose use. Each source has its own enable, and each is passed through a two-flop synchroniser before it is used.

On a wake, the clock tree comes back in a fixed order. The oscillator is enabled first. The PLL is enabled only once the oscillator reports ready, and it is given a fixed settle window. Only after that window does the wakeup interrupt reach the CPU, together with a latched record of which sources caused the wake.

Top module: `pwr_wake_seq`

## Requirements
- R1: After `rst` falls, `cpu_rst` stays high for exactly `RST_XTAL_CYC` rising edges when `rst_kind` is 0 (power-on, crystal), and for exactly `RST_WARM_CYC` edges when `rst_kind` is 2 (reset while powered).
- R2: When `rst_kind` is 1 (power-on, external clock), `cpu_rst` stays high for at least `RST_EXT_CYC` edges and then until `osc_ready` is seen high.
- R3: While `rst` is high, `cpu_rst`, `osc_en` and `pll_en` are all 1, `wake_irq` is 0 and `wake_cause` is 0.
- R4: While the CPU is running, a cycle with `pd_wr`=1 and `pd_set`=1 drives `osc_en` and `pll_en` to 0 from the next edge on. A write with `pd_set`=0 changes neither output.
- R5: On a wake, `osc_en` rises first while `pll_en` stays 0. `pll_en` rises on the edge after `osc_ready` is seen high. `wake_irq` rises exactly `PLL_SETTLE_CYC` edges after `pll_en` rises.
- R6: The primary wake pin is active low when `wake_pol`=0 and active high when `wake_pol`=1.
- R7: A source whose enable (`en_usb`, `en_wk`, `en_wu2`) is 0 cannot end power-down.
- R8: When `wu2_gpio`=1, the second wake pin cannot end power-down.
- R9: `wake_cause` shows the enabled sources that were active in the cycle the wake was taken (bit 0 USB, bit 1 primary pin, bit 2 second pin). It becomes visible as `wake_irq` rises. A cycle with `irq_clr`=1 clears both `wake_irq` and `wake_cause`.
- R10: Wake events that arrive while the restart sequence is running are absorbed: the sequence is not restarted and `wake_cause` is not changed.
- R11: If `irq_clr` is high in the same cycle that a new wakeup interrupt is raised, the new interrupt and its cause win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset request |
| rst_kind | input | 2 | Reset kind: 0 power-on crystal, 1 power-on external clock, 2 powered |
| osc_ready | input | 1 | Oscillator/clock stable indication |
| pd_wr | input | 1 | Write strobe to the power-control bit |
| pd_set | input | 1 | Value written to the power-down bit |
| usb_act | input | 1 | Asynchronous USB bus activity, active high |
| wake_pin | input | 1 | Asynchronous primary wake pin, polarity by `wake_pol` |
| wu2_pin | input | 1 | Asynchronous second wake pin, active high |
| wu2_gpio | input | 1 | 1: second pin is general-purpose and not a wake source |
| wake_pol | input | 1 | Primary wake pin polarity, 0 active low |
| en_usb | input | 1 | Enable for USB activity wake |
| en_wk | input | 1 | Enable for primary pin wake |
| en_wu2 | input | 1 | Enable for second pin wake |
| irq_clr | input | 1 | Acknowledge: clears interrupt and cause |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_rst | output | 1 | CPU reset, active high |
| wake_irq | output | 1 | Wakeup interrupt |
| wake_cause | output | 3 | Latched wake sources |

## Verification
Two events can land on the same edge: the raising of a new wakeup interrupt at the end of the PLL settle window, and a CPU acknowledge of an older interrupt. To provoke this, the bench powers down without acknowledging the previous wake. It then wakes through the second pin and holds `irq_clr` high across the whole settle window. The result is judged on the edge where the window ends: `wake_irq` must be 1 and `wake_cause` must hold only the second-pin bit. A further pair of events is also checked. A wake source that toggles during the restart must leave the settle length and the cause unchanged.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [2:0] {
        ST_RST    = 3'd0,
        ST_CLKW   = 3'd1,
        ST_RUN    = 3'd2,
        ST_PDN    = 3'd3,
        ST_OSCW   = 3'd4,
        ST_SETTLE = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        RK_POR_XTAL = 2'd0,
        RK_POR_EXT  = 2'd1,
        RK_WARM     = 2'd2
    } rst_kind_t;

    // bit 0 usb, bit 1 primary pin, bit 2 second pin
    typedef struct packed {
        logic wu2;
        logic wkp;
        logic usb;
    } wake_vec_t;

    localparam int WAKE_N = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pws_wake_detect.sv
module pws_wake_detect
    import pws_pkg::*;
(
    input  wake_vec_t s,
    input  wake_vec_t en,
    input  logic      pol,
    input  logic      wu2_gpio,
    output wake_vec_t hit
);
    always_comb begin
        hit.usb = s.usb & en.usb;
        hit.wkp = (pol ? s.wkp : ~s.wkp) & en.wkp;
        hit.wu2 = s.wu2 & en.wu2 & ~wu2_gpio;
    end
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
    import pws_pkg::*;
#(
    parameter int RST_XTAL_CYC   = 40,
    parameter int RST_EXT_CYC    = 12,
    parameter int RST_WARM_CYC   = 10,
    parameter int PLL_SETTLE_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rst_kind,
    input  logic       osc_ready,
    input  logic       pd_req,
    input  wake_vec_t  hit,
    output seq_state_t state,
    output wake_vec_t  pend_cause,
    output logic       irq_set
);
    localparam int CNT_MAX = max3(max3(RST_XTAL_CYC, RST_EXT_CYC, RST_WARM_CYC), PLL_SETTLE_CYC, 2);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PLL_LAST = CNT_W'(PLL_SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_last;

    always_comb begin
        case (rst_kind_t'(rst_kind))
            RK_POR_XTAL: hold_last = CNT_W'(RST_XTAL_CYC - 1);
            RK_POR_EXT:  hold_last = CNT_W'(RST_EXT_CYC - 1);
            default:     hold_last = CNT_W'(RST_WARM_CYC - 1);
        endcase
    end

    assign irq_set = (state == ST_SETTLE) && (cnt == PLL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RST;
            cnt        <= '0;
            pend_cause <= '0;
        end else begin
            case (state)
                ST_RST: begin
                    if (cnt == hold_last) begin
                        cnt   <= '0;
                        state <= (rst_kind_t'(rst_kind) == RK_POR_EXT) ? ST_CLKW : ST_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CLKW: if (osc_ready) state <= ST_RUN;
                ST_RUN:  if (pd_req)    state <= ST_PDN;
                ST_PDN: begin
                    if (|hit) begin
                        pend_cause <= hit;
                        state      <= ST_OSCW;
                    end
                end
                ST_OSCW: begin
                    if (osc_ready) begin
                        cnt   <= '0;
                        state <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == PLL_LAST) begin
                        cnt   <= '0;
                        state <= ST_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_RST;
            endcase
        end
    end
endmodule

// File: rtl/pws_irq.sv
module pws_irq
    import pws_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      set,
    input  logic      clr,
    input  wake_vec_t pend_cause,
    output logic      irq,
    output wake_vec_t cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq   <= 1'b0;
            cause <= '0;
        end else if (set) begin
            irq   <= 1'b1;
            cause <= pend_cause;
        end else if (clr) begin
            irq   <= 1'b0;
            cause <= '0;
        end
    end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
    import pws_pkg::*;
#(
    parameter int RST_XTAL_CYC   = 40,
    parameter int RST_EXT_CYC    = 12,
    parameter int RST_WARM_CYC   = 10,
    parameter int PLL_SETTLE_CYC = 6,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rst_kind,
    input  logic       osc_ready,
    input  logic       pd_wr,
    input  logic       pd_set,
    input  logic       usb_act,
    input  logic       wake_pin,
    input  logic       wu2_pin,
    input  logic       wu2_gpio,
    input  logic       wake_pol,
    input  logic       en_usb,
    input  logic       en_wk,
    input  logic       en_wu2,
    input  logic       irq_clr,
    output logic       osc_en,
    output logic       pll_en,
    output logic       cpu_rst,
    output logic       wake_irq,
    output logic [2:0] wake_cause
);
    logic [WAKE_N-1:0] raw_in;
    logic [WAKE_N-1:0] sync_out;
    wake_vec_t         synced;
    wake_vec_t         enables;
    wake_vec_t         hit;
    wake_vec_t         pend_cause;
    wake_vec_t         cause_q;
    seq_state_t        state;
    logic              irq_set;

    assign raw_in  = {wu2_pin, wake_pin, usb_act};
    assign synced  = wake_vec_t'(sync_out);
    assign enables = '{wu2: en_wu2, wkp: en_wk, usb: en_usb};

    pws_sync #(.W(WAKE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    pws_wake_detect u_detect (
        .s        (synced),
        .en       (enables),
        .pol      (wake_pol),
        .wu2_gpio (wu2_gpio),
        .hit      (hit)
    );

    pws_ctrl #(
        .RST_XTAL_CYC   (RST_XTAL_CYC),
        .RST_EXT_CYC    (RST_EXT_CYC),
        .RST_WARM_CYC   (RST_WARM_CYC),
        .PLL_SETTLE_CYC (PLL_SETTLE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rst_kind   (rst_kind),
        .osc_ready  (osc_ready),
        .pd_req     (pd_wr & pd_set),
        .hit        (hit),
        .state      (state),
        .pend_cause (pend_cause),
        .irq_set    (irq_set)
    );

    pws_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .set        (irq_set),
        .clr        (irq_clr),
        .pend_cause (pend_cause),
        .irq        (wake_irq),
        .cause      (cause_q)
    );

    assign wake_cause = cause_q;
    assign osc_en     = (state != ST_PDN);
    assign pll_en     = (state != ST_PDN) && (state != ST_OSCW);
    assign cpu_rst    = rst || (state == ST_RST) || (state == ST_CLKW);
endmodule

// File: rtl/pws_chk.sv
module pws_chk
    import pws_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pd_wr,
    input logic       pd_set,
    input logic       osc_en,
    input logic       pll_en,
    input logic       cpu_rst,
    input logic       wake_irq,
    input seq_state_t state,
    input wake_vec_t  pend_cause
);
    // R5
    pll_after_osc_chk: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> osc_en);

    // R4
    pd_stops_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pd_wr && pd_set) |=> (!osc_en && !pll_en));

    // R5
    irq_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_irq) |-> ($past(state) == ST_SETTLE));

    // R3
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> $past(!rst));

    // R10
    cause_absorbed_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OSCW || state == ST_SETTLE) |=> $stable(pend_cause));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE) |=> (state == ST_SETTLE || state == ST_RUN));
endmodule

bind pwr_wake_seq pws_chk u_chk (.*);

// File: tb/pwr_wake_seq_test.sv
module pwr_wake_seq_test;
    localparam int XTAL = 40;
    localparam int EXT  = 12;
    localparam int WARM = 10;
    localparam int PLL  = 6;

    logic clk = 0;
    logic rst = 1;
    logic [1:0] rst_kind = 2'd0;
    logic osc_ready = 1;
    logic pd_wr = 0, pd_set = 0;
    logic usb_act = 0, wake_pin = 1, wu2_pin = 0, wu2_gpio = 0, wake_pol = 0;
    logic en_usb = 1, en_wk = 1, en_wu2 = 1, irq_clr = 0;
    logic osc_en, pll_en, cpu_rst, wake_irq;
    logic [2:0] wake_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_wake_seq #(
        .RST_XTAL_CYC(XTAL), .RST_EXT_CYC(EXT), .RST_WARM_CYC(WARM), .PLL_SETTLE_CYC(PLL)
    ) uut (
        .clk(clk), .rst(rst), .rst_kind(rst_kind), .osc_ready(osc_ready),
        .pd_wr(pd_wr), .pd_set(pd_set), .usb_act(usb_act), .wake_pin(wake_pin),
        .wu2_pin(wu2_pin), .wu2_gpio(wu2_gpio), .wake_pol(wake_pol),
        .en_usb(en_usb), .en_wk(en_wk), .en_wu2(en_wu2), .irq_clr(irq_clr),
        .osc_en(osc_en), .pll_en(pll_en), .cpu_rst(cpu_rst),
        .wake_irq(wake_irq), .wake_cause(wake_cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // drive sources: bit0 usb, bit1 primary pin, bit2 second pin
    task automatic apply(input logic [2:0] stim);
        usb_act  = stim[0];
        wake_pin = stim[1] ? wake_pol : ~wake_pol;
        wu2_pin  = stim[2];
    endtask

    task automatic do_reset(input logic [1:0] kind, input int lim, input string req);
        int n;
        @(negedge clk);
        rst = 1; rst_kind = kind; osc_ready = (kind != 2'd1);
        repeat (3) @(negedge clk);
        // R3
        chk(cpu_rst && osc_en && pll_en, "R3 clocks/reset during rst", {cpu_rst, osc_en, pll_en}, 7);
        chk(!wake_irq && wake_cause == 0, "R3 irq/cause clear", {wake_irq, wake_cause}, 0);
        rst = 0;
        n = 0;
        while (cpu_rst && n < 200) begin
            @(negedge clk); n++;
            if (kind == 2'd1 && n == lim + 3) begin
                chk(cpu_rst == 1, "R2 wait for clock stable", cpu_rst, 1);
                osc_ready = 1;
            end
        end
        if (kind == 2'd1) chk(n == lim + 4, "R2 ext-clock release", n, lim + 4);
        else              chk(n == lim, req, n, lim);
    endtask

    task automatic power_down(input string req);
        @(negedge clk); pd_wr = 1; pd_set = 1;
        @(negedge clk); pd_wr = 0; pd_set = 0;
        chk(!osc_en && !pll_en, {req, " R4 clocks off"}, {osc_en, pll_en}, 0);
        osc_ready = 0;
    endtask

    task automatic wake_seq(input logic [2:0] stim, input bit expect_wake,
                            input logic [2:0] exp_cause, input bit do_clear, input string req);
        int n;
        bit ok;
        power_down(req);
        @(negedge clk); apply(stim);
        if (!expect_wake) begin
            repeat (10) @(negedge clk);
            chk(osc_en == 0, {req, " blocked source"}, osc_en, 0);
            apply(stim | 3'b001);
        end
        n = 0;
        while (!osc_en && n < 10) begin @(negedge clk); n++; end
        chk(osc_en == 1 && pll_en == 0, "R5 osc first", {osc_en, pll_en}, 2);
        repeat (3) @(negedge clk);
        chk(pll_en == 0 && wake_irq == (do_clear ? 0 : wake_irq), "R5 pll waits for osc", pll_en, 0);
        osc_ready = 1;
        @(negedge clk);
        chk(pll_en == 1, "R5 pll after osc ready", pll_en, 1);
        n = 0; ok = 1;
        while (!(wake_irq && n > 0) && n < 50) begin
            @(negedge clk); n++;
            if (!pll_en) ok = 0;
        end
        chk(n == PLL && ok, "R5 settle length", n, PLL);
        chk(wake_cause == exp_cause, {req, " R9 cause"}, wake_cause, exp_cause);
        apply(3'b000);
        if (do_clear) begin
            @(negedge clk); irq_clr = 1;
            @(negedge clk); irq_clr = 0;
            chk(!wake_irq && wake_cause == 0, "R9 clear", {wake_irq, wake_cause}, 0);
        end
    endtask

    task automatic t_pd_noop();
        @(negedge clk); pd_wr = 1; pd_set = 0;
        @(negedge clk); pd_wr = 0;
        repeat (2) @(negedge clk);
        chk(osc_en && pll_en, "R4 write of 0 ignored", {osc_en, pll_en}, 3);
    endtask

    task automatic t_absorb();
        int n;
        power_down("R10");
        @(negedge clk); apply(3'b010);
        n = 0;
        while (!osc_en && n < 10) begin @(negedge clk); n++; end
        usb_act = 1;
        repeat (3) @(negedge clk);
        usb_act = 0;
        osc_ready = 1;
        @(negedge clk);
        n = 0;
        while (!wake_irq && n < 50) begin
            @(negedge clk); n++;
            usb_act = ~usb_act;
        end
        chk(n == PLL, "R10 settle not restarted", n, PLL);
        chk(wake_cause == 3'b010, "R10 cause unchanged", wake_cause, 2);
        apply(3'b000);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    task automatic t_collide();
        int n;
        wake_seq(3'b001, 1, 3'b001, 0, "R11 first wake");
        chk(wake_irq == 1, "R11 irq left pending", wake_irq, 1);
        power_down("R11");
        @(negedge clk); apply(3'b100);
        n = 0;
        while (!osc_en && n < 10) begin @(negedge clk); n++; end
        osc_ready = 1; irq_clr = 1;
        @(negedge clk);
        n = 0;
        while (n < PLL) begin
            @(negedge clk); n++;
            if (n == 1) chk(wake_irq == 0, "R11 old irq cleared", wake_irq, 0);
        end
        chk(wake_irq == 1, "R11 set wins", wake_irq, 1);
        chk(wake_cause == 3'b100, "R11 new cause kept", wake_cause, 4);
        irq_clr = 0; apply(3'b000);
        @(negedge clk);
        chk(wake_irq == 1, "R11 irq holds", wake_irq, 1);
        irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        do_reset(2'd0, XTAL, "R1 crystal power-on hold");
        do_reset(2'd2, WARM, "R1 warm hold");
        do_reset(2'd1, EXT,  "R2");
        t_pd_noop();
        wake_seq(3'b001, 1, 3'b001, 1, "usb wake");
        wake_seq(3'b010, 1, 3'b010, 1, "R6 active-low pin");
        @(negedge clk); wake_pol = 1; apply(3'b000);
        wake_seq(3'b010, 1, 3'b010, 1, "R6 active-high pin");
        wake_seq(3'b100, 1, 3'b100, 1, "second pin");
        @(negedge clk); en_wk = 0;
        wake_seq(3'b010, 0, 3'b001, 1, "R7 pin disabled");
        @(negedge clk); en_wk = 1; en_usb = 0; wu2_gpio = 0;
        wake_seq(3'b100, 1, 3'b100, 1, "R7 usb disabled");
        @(negedge clk); en_usb = 1; wu2_gpio = 1;
        wake_seq(3'b100, 0, 3'b001, 1, "R8 gpio mode");
        @(negedge clk); wu2_gpio = 0;
        t_absorb();
        t_collide();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule